// File: doc/BRIEF.md
# Priority Interrupt Arbiter with Mask Write-Back

The block gathers level-sensitive requests from a set of external pins and on-chip modules, plus a single non-maskable request. Each maskable source has its own programmable priority. Every cycle the block finds the highest-priority request that the CPU may currently take and presents it as a request flag, a level code and a source code. Whether a request may be taken depends on the CPU's interrupt mask level, its block bit, and a separate threshold that applies only in user mode.

The non-maskable request is caught on a rising edge of its pin. It stays pending until the CPU acknowledges it, and it outranks every maskable source. A control bit selects whether the CPU block bit also holds it off.

When the CPU acknowledges the presented request, the block returns the accepted level as the new mask value for the CPU status register, together with a one-cycle strobe. Software sets priorities, the user threshold and the non-maskable blocking option through a plain write/read register port. The same port shows the live level of the non-maskable pin.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the request output is 0, the level and source codes are 0, the update strobe is 0, and every register reads back 0, apart from the pin-level bit, which follows the pin.
- R2: A write to address s (0 ≤ s < NUM_EXT+NUM_MOD) stores bits 3:0 of the write data as the priority of source s, and a read of s returns it zero-extended. The control register sits at address 0x30: bit 0 is the non-maskable block enable (read/write) and bit 1 is read-only. The user threshold sits at address 0x31, bits 3:0.
- R3: A maskable source is eligible only when its request is high, its priority is non-zero, and its priority is strictly greater than the CPU mask level. A priority of 0 disables the source.
- R4: Among eligible sources the highest priority wins. On a tie the lowest source index wins. External pins are sources 0..NUM_EXT-1 and on-chip modules follow in index order.
- R5: While the CPU block bit is 1, no maskable request is presented.
- R6: A rising edge on the non-maskable pin latches a pending request. That request is presented two cycles after the edge, with level code 16 and source code NUM_EXT+NUM_MOD, and it outranks all maskable sources. An acknowledge while it is presented clears it. A pin held high does not raise it again.
- R7: If control bit 0 is 1, the block bit also holds off the pending non-maskable request, which is kept latched until the block bit drops. If control bit 0 is 0, the request is presented even while the block bit is 1.
- R8: While the CPU is in user mode, a maskable source whose priority is not strictly greater than the user threshold is suppressed.
- R9: An acknowledge while a request is presented produces, one cycle later, a one-cycle update strobe. The new-mask value that comes with it is the accepted level, or 15 for the non-maskable level.
- R10: Control register bit 1 reads the current level of the non-maskable pin.
- R11: The request, level and source outputs are registered. They reflect the inputs and registers as sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| extIrq | input | NUM_EXT | External pin requests (sources 0..NUM_EXT-1) |
| modIrq | input | NUM_MOD | On-chip module requests (sources NUM_EXT..) |
| nmiPin | input | 1 | Non-maskable request pin |
| cpuMask | input | 4 | Current CPU interrupt mask level |
| cpuBlock | input | 1 | CPU block bit |
| cpuUserMode | input | 1 | CPU is in user mode |
| intAck | input | 1 | CPU accepts the presented request |
| regWrEn | input | 1 | Register write enable |
| regAddr | input | 6 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| intReq | output | 1 | A request is presented |
| intLevel | output | 5 | Level of the presented request (16 = non-maskable) |
| intSrc | output | 5 | Source code of the presented request |
| maskUpdStrb | output | 1 | One-cycle strobe for the new mask value |
| maskUpdVal | output | 4 | New CPU mask value |

## Verification
The assertions check on every cycle that each presented maskable level lies strictly above the mask level and the user threshold seen one cycle earlier. They also check that nothing maskable appears after a blocked cycle, that a non-maskable level always carries its own source code and respects the block option, and that each update strobe follows an acknowledge of a live request. Only the bench's scenarios can show which source wins a priority tie, that a zero priority silences a source, that the pending non-maskable request is held across a blocked period and cleared by acknowledge without re-arming from a high pin, and what value returns as the new mask.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int PRIO_W = 4;
  localparam int LVL_W  = PRIO_W + 1;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] CTRL_ADDR  = 6'h30;
  localparam logic [ADDR_W-1:0] UMASK_ADDR = 6'h31;
  localparam logic [LVL_W-1:0]  NMI_LVL    = LVL_W'(1 << PRIO_W);

  typedef struct packed {
    logic prioWe;
    logic ctrlWe;
    logic umaskWe;
    logic nmiPend;
  } dpStrobes_t;
endpackage

// File: rtl/irq_prio_ctl.sv
module irq_prio_ctl
  import irq_prio_pkg::*;
#(
  parameter int NSRC  = 17,
  parameter int SRC_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              nmiPin,
  input  logic              intAck,
  input  logic              intReq,
  input  logic [LVL_W-1:0]  intLevel,
  input  logic [SRC_W-1:0]  intSrc,
  output dpStrobes_t        strb,
  output logic              maskUpdStrb,
  output logic [PRIO_W-1:0] maskUpdVal
);
  localparam logic [SRC_W-1:0] NMI_SRC = SRC_W'(NSRC);

  logic nmiPinQ;
  logic nmiPend;
  logic nmiRise;
  logic nmiTaken;
  logic accepted;

  assign nmiRise  = nmiPin & ~nmiPinQ;
  assign accepted = intAck & intReq;
  assign nmiTaken = accepted & (intSrc == NMI_SRC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmiPinQ     <= 1'b0;
      nmiPend     <= 1'b0;
      maskUpdStrb <= 1'b0;
      maskUpdVal  <= '0;
    end else begin
      nmiPinQ <= nmiPin;
      if (nmiRise) nmiPend <= 1'b1;
      else if (nmiTaken) nmiPend <= 1'b0;
      maskUpdStrb <= accepted;
      if (accepted)
        maskUpdVal <= intLevel[PRIO_W] ? '1 : intLevel[PRIO_W-1:0];
    end
  end

  always_comb begin
    strb.prioWe  = regWrEn && (int'(regAddr) < NSRC);
    strb.ctrlWe  = regWrEn && (regAddr == CTRL_ADDR);
    strb.umaskWe = regWrEn && (regAddr == UMASK_ADDR);
    strb.nmiPend = nmiPend;
  end

  // R9
  upd_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    maskUpdStrb |-> $past(intAck && intReq));

  // R6
  nmi_set_by_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmiPend) |-> $past(nmiPin));
endmodule

// File: rtl/irq_prio_dp.sv
module irq_prio_dp
  import irq_prio_pkg::*;
#(
  parameter int NSRC  = 17,
  parameter int SRC_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobes_t        strb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              nmiPin,
  input  logic [NSRC-1:0]   srcReq,
  input  logic [PRIO_W-1:0] cpuMask,
  input  logic              cpuBlock,
  input  logic              cpuUserMode,
  output logic              intReq,
  output logic [LVL_W-1:0]  intLevel,
  output logic [SRC_W-1:0]  intSrc
);
  localparam logic [SRC_W-1:0] NMI_SRC = SRC_W'(NSRC);

  logic [PRIO_W-1:0] prioQ [NSRC];
  logic [NSRC-1:0]   elig;
  logic              nmiBlockEn;
  logic [PRIO_W-1:0] userMask;
  logic [LVL_W-1:0]  bestLvl;
  logic [SRC_W-1:0]  bestSrc;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prioQ[g] <= '0;
      else if (strb.prioWe && int'(regAddr) == g) prioQ[g] <= regWrData[PRIO_W-1:0];
    end
    assign elig[g] = srcReq[g] && (prioQ[g] != '0) && (prioQ[g] > cpuMask) && !cpuBlock
                     && !(cpuUserMode && (prioQ[g] <= userMask));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmiBlockEn <= 1'b0;
      userMask   <= '0;
    end else begin
      if (strb.ctrlWe)  nmiBlockEn <= regWrData[0];
      if (strb.umaskWe) userMask   <= regWrData[PRIO_W-1:0];
    end
  end

  always_comb begin
    regRdData = '0;
    for (int i = 0; i < NSRC; i++)
      if (int'(regAddr) == i) regRdData = DATA_W'(prioQ[i]);
    if (regAddr == CTRL_ADDR)  regRdData = DATA_W'({nmiPin, nmiBlockEn});
    if (regAddr == UMASK_ADDR) regRdData = DATA_W'(userMask);
  end

  always_comb begin
    bestLvl = '0;
    bestSrc = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i] && ({1'b0, prioQ[i]} > bestLvl)) begin
        bestLvl = {1'b0, prioQ[i]};
        bestSrc = SRC_W'(i);
      end
    end
    if (strb.nmiPend && !(cpuBlock && nmiBlockEn)) begin
      bestLvl = NMI_LVL;
      bestSrc = NMI_SRC;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intReq   <= 1'b0;
      intLevel <= '0;
      intSrc   <= '0;
    end else begin
      intReq   <= (bestLvl != '0);
      intLevel <= bestLvl;
      intSrc   <= bestSrc;
    end
  end

  // R3
  above_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (intReq && !intLevel[PRIO_W]) |-> (intLevel[PRIO_W-1:0] > $past(cpuMask)));

  // R5
  blk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (intReq && !intLevel[PRIO_W]) |-> !$past(cpuBlock));

  // R8
  user_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (intReq && !intLevel[PRIO_W] && $past(cpuUserMode)) |-> (intLevel[PRIO_W-1:0] > $past(userMask)));

  // R6
  nmi_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (intReq && intLevel[PRIO_W]) |-> (intSrc == NMI_SRC && $past(strb.nmiPend)));

  // R7
  nmi_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (intReq && intLevel[PRIO_W]) |-> !($past(cpuBlock) && $past(nmiBlockEn)));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NUM_EXT = 4,
  parameter int NUM_MOD = 13,
  localparam int NSRC  = NUM_EXT + NUM_MOD,
  localparam int SRC_W = $clog2(NSRC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] extIrq,
  input  logic [NUM_MOD-1:0] modIrq,
  input  logic               nmiPin,
  input  logic [PRIO_W-1:0]  cpuMask,
  input  logic               cpuBlock,
  input  logic               cpuUserMode,
  input  logic               intAck,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic               intReq,
  output logic [LVL_W-1:0]   intLevel,
  output logic [SRC_W-1:0]   intSrc,
  output logic               maskUpdStrb,
  output logic [PRIO_W-1:0]  maskUpdVal
);
  dpStrobes_t strb;

  irq_prio_ctl #(.NSRC(NSRC), .SRC_W(SRC_W)) ctl_i (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .nmiPin(nmiPin), .intAck(intAck), .intReq(intReq), .intLevel(intLevel),
    .intSrc(intSrc), .strb(strb), .maskUpdStrb(maskUpdStrb), .maskUpdVal(maskUpdVal)
  );

  irq_prio_dp #(.NSRC(NSRC), .SRC_W(SRC_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .nmiPin(nmiPin), .srcReq({modIrq, extIrq}),
    .cpuMask(cpuMask), .cpuBlock(cpuBlock), .cpuUserMode(cpuUserMode),
    .intReq(intReq), .intLevel(intLevel), .intSrc(intSrc)
  );
endmodule

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_EXT = 4;
  localparam int NUM_MOD = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NUM_EXT-1:0] extIrq = '0;
  logic [NUM_MOD-1:0] modIrq = '0;
  logic nmiPin = 1'b0;
  logic [3:0] cpuMask = '0;
  logic cpuBlock = 1'b0;
  logic cpuUserMode = 1'b0;
  logic intAck = 1'b0;
  logic regWrEn = 1'b0;
  logic [5:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic intReq;
  logic [4:0] intLevel;
  logic [4:0] intSrc;
  logic maskUpdStrb;
  logic [3:0] maskUpdVal;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  typedef struct {
    bit    req;
    int    lvl;
    int    src;
    bit    upd;
    int    updVal;
    string tag;
  } expItem_t;

  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctrl #(.NUM_EXT(NUM_EXT), .NUM_MOD(NUM_MOD)) dut_i (
    .clk(clk), .rst_n(rst_n), .extIrq(extIrq), .modIrq(modIrq), .nmiPin(nmiPin),
    .cpuMask(cpuMask), .cpuBlock(cpuBlock), .cpuUserMode(cpuUserMode), .intAck(intAck),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .intReq(intReq), .intLevel(intLevel), .intSrc(intSrc),
    .maskUpdStrb(maskUpdStrb), .maskUpdVal(maskUpdVal)
  );

  // monitor: compares after each rising edge
  always @(posedge clk) begin
    expItem_t it;
    #(CLK_PERIOD/4);
    if (expQ.size() > 0) begin
      it = expQ.pop_front();
      nChecks++;
      if (intReq !== it.req || int'(intLevel) != it.lvl || int'(intSrc) != it.src ||
          maskUpdStrb !== it.upd || (it.upd && int'(maskUpdVal) != it.updVal)) begin
        nFails++;
        $display("FAIL %s: got req=%0b lvl=%0d src=%0d upd=%0b val=%0d, exp req=%0b lvl=%0d src=%0d upd=%0b val=%0d",
                 it.tag, intReq, intLevel, intSrc, maskUpdStrb, maskUpdVal,
                 it.req, it.lvl, it.src, it.upd, it.updVal);
      end
    end
  end

  task automatic step(bit req, int lvl, int src, bit upd, int updVal, string tag);
    expItem_t it;
    it.req = req; it.lvl = lvl; it.src = src; it.upd = upd; it.updVal = updVal; it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic chkRd(logic [5:0] a, logic [7:0] e, string tag);
    regAddr = a;
    #1;
    nChecks++;
    if (regRdData !== e) begin
      nFails++;
      $display("FAIL %s: read addr %0h got %0h exp %0h", tag, a, regRdData, e);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    nFails++;
    nChecks++;
    $display("FAIL watchdog: got timeout exp completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    nChecks++;
    if (intReq !== 1'b0 || intLevel !== 5'd0 || intSrc !== 5'd0 || maskUpdStrb !== 1'b0) begin
      nFails++;
      $display("FAIL R1: got req=%0b lvl=%0d src=%0d upd=%0b exp all 0", intReq, intLevel, intSrc, maskUpdStrb);
    end
    chkRd(6'd3, 8'h00, "R1 prio reset");
    chkRd(6'h30, 8'h00, "R1 ctrl reset");
    chkRd(6'h31, 8'h00, "R1 umask reset");
    @(negedge clk);

    // R2 programming
    wr(6'd0, 8'd5);
    wr(6'd1, 8'd9);
    wr(6'd2, 8'd9);
    wr(6'd3, 8'hF7);
    wr(6'd5, 8'd12);
    wr(6'd16, 8'd3);
    wr(6'h31, 8'd6);
    chkRd(6'd1, 8'd9, "R2 prio readback");
    chkRd(6'd3, 8'd7, "R2 prio low nibble");
    chkRd(6'h31, 8'd6, "R2 umask readback");

    step(0, 0, 0, 0, 0, "R1 idle");
    extIrq = 4'b0001;
    step(1, 5, 0, 0, 0, "R11 one cycle latency");
    cpuMask = 4'd5;
    step(0, 0, 0, 0, 0, "R3 equal to mask");
    cpuMask = 4'd4;
    step(1, 5, 0, 0, 0, "R3 above mask");
    cpuMask = 4'd0;
    extIrq = 4'b0111;
    step(1, 9, 1, 0, 0, "R4 tie lowest index");
    modIrq[1] = 1'b1;
    step(1, 12, 5, 0, 0, "R4 highest priority");
    extIrq = '0; modIrq = '0; modIrq[0] = 1'b1;
    step(0, 0, 0, 0, 0, "R3 zero priority");
    modIrq = '0; modIrq[1] = 1'b1; cpuBlock = 1'b1;
    step(0, 0, 0, 0, 0, "R5 block");
    cpuBlock = 1'b0;
    step(1, 12, 5, 0, 0, "R5 unblock");

    modIrq = '0; cpuUserMode = 1'b1; extIrq = 4'b0001;
    step(0, 0, 0, 0, 0, "R8 below user mask");
    extIrq = 4'b0011;
    step(1, 9, 1, 0, 0, "R8 above user mask");
    cpuUserMode = 1'b0; extIrq = 4'b0001;
    step(1, 5, 0, 0, 0, "R8 supervisor");

    extIrq = 4'b0010;
    step(1, 9, 1, 0, 0, "R9 setup");
    intAck = 1'b1;
    step(1, 9, 1, 1, 9, "R9 mask update");
    intAck = 1'b0;
    step(1, 9, 1, 0, 0, "R9 single strobe");
    extIrq = '0;

    modIrq[1] = 1'b1; nmiPin = 1'b1;
    step(1, 12, 5, 0, 0, "R6 edge latency");
    step(1, 16, 17, 0, 0, "R6 nmi presented");
    chkRd(6'h30, 8'h02, "R10 pin level");
    intAck = 1'b1;
    step(1, 16, 17, 1, 15, "R9 nmi mask value");
    intAck = 1'b0;
    step(1, 12, 5, 0, 0, "R6 ack clears");
    step(1, 12, 5, 0, 0, "R6 no retrigger");

    nmiPin = 1'b0;
    step(1, 12, 5, 0, 0, "R7 pin low");
    cpuBlock = 1'b1; nmiPin = 1'b1;
    step(0, 0, 0, 0, 0, "R7 latency under block");
    step(1, 16, 17, 0, 0, "R7 nmi passes block");
    intAck = 1'b1;
    step(1, 16, 17, 1, 15, "R7 ack");
    intAck = 1'b0;
    step(0, 0, 0, 0, 0, "R7 cleared under block");

    wr(6'h30, 8'h01);
    chkRd(6'h30, 8'h03, "R10 pin and enable");
    nmiPin = 1'b0;
    step(0, 0, 0, 0, 0, "R7 pin low");
    nmiPin = 1'b1;
    step(0, 0, 0, 0, 0, "R7 edge");
    step(0, 0, 0, 0, 0, "R7 nmi held off");
    cpuBlock = 1'b0;
    step(1, 16, 17, 0, 0, "R7 latched nmi released");
    intAck = 1'b1;
    step(1, 16, 17, 1, 15, "R7 ack");
    intAck = 1'b0;
    step(1, 12, 5, 0, 0, "R7 back to maskable");

    @(negedge clk);
    @(negedge clk);
    finish();
  end
endmodule